// File: doc/BRIEF.md
# SMRAM Access Guard and Window Remapper

This block sits at the front of a memory controller and screens processor requests against the protected system-management memory regions. It holds an 8-bit control register that software programs through a simple write port; the register's size and enable fields can be frozen by an external lock line. Every request is routed either to local DRAM or to the downstream I/O port. A DRAM-bound request that falls in the high SMRAM window gets its address translated down into the legacy region.

Two regions are protected. The first is a fixed 128 KB high window at 0xFEDA0000..0xFEDBFFFF. It is active when the global enable input and the register's high-window bit are both set. The second is a top-of-memory segment of 1 MB or 2 MB. Its upper bound is the top of usable memory minus the GTT size and the stolen graphics size, and those three values arrive as inputs.

A request that is not in management mode and that hits an active region while the override input is low is sent to the I/O port. The same request also sets a sticky error bit in the register. Software clears that bit by writing a one to it.

Top module: `smram_guard`

## Requirements
- R1: After reset the register reads 0x38.
- R2: Bits 5, 4 and 3 always read 1 and bit 0 always reads 0, whatever is written.
- R3: A write updates bit 7 (high window enable) and bits 2:1 (segment size code) only while lockIn is 0. While lockIn is 1 those bits keep their value.
- R4: When smramEnIn and bit 7 are both 1, a request in 0xFEDA0000..0xFEDBFFFF that is allowed to reach DRAM is routed to DRAM at address (reqAddr - 0xFEDA0000 + 0x000A0000).
- R5: When smramEnIn or bit 7 is 0, requests in the high window reach DRAM with the address unchanged and never set the error bit.
- R6: The segment is [E - S, E), where E = topMem - gttSize - stolenSize. S is 1 MB for size code 00 and 2 MB for size code 01. Addresses equal to E - S and E - 1 are inside the segment; E - S - 1 and E are outside.
- R7: A valid request with reqSmm = 0 and openOvr = 0 that hits an active region drives routeIo = 1 in the same cycle and sets bit 6 at the next clock edge. With reqValid = 0, routeIo stays 0 and bit 6 is not set.
- R8: Size codes 10 and 11 disable the segment, so addresses in the would-be segment reach DRAM unchanged and set no error.
- R9: A request with reqSmm = 1, or any request while openOvr = 1, is routed to DRAM and does not set bit 6.
- R10: Bit 6 stays set until a write with data bit 6 = 1 clears it. A write with data bit 6 = 0 leaves it set.
- R11: If a setting request and a clearing write occur in the same cycle, bit 6 ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgWrData | input | 8 | Register write data |
| cfgRdData | output | 8 | Current register value |
| lockIn | input | 1 | Freezes the enable and size fields when 1 |
| smramEnIn | input | 1 | Global SMRAM enable |
| openOvr | input | 1 | Open override: lets non-management requests into protected regions |
| reqValid | input | 1 | Request present this cycle |
| reqSmm | input | 1 | Request issued in management mode |
| reqAddr | input | 32 | Request address |
| topMem | input | 32 | Top of usable memory |
| gttSize | input | 32 | GTT carve-out size in bytes |
| stolenSize | input | 32 | Stolen graphics memory size in bytes |
| routeIo | output | 1 | 1: forward to downstream I/O port; 0: serve from DRAM |
| dramAddr | output | 32 | DRAM address for the request (remapped in the high window) |

## Verification
The assertions assume that topMem is at least gttSize + stolenSize + 2 MB, so the segment bounds never wrap. They also assume that the segment never overlaps the high window. Every carve-out configuration in the stimulus keeps the segment far below 0xFED00000 with ample room under topMem. The lock, override and enable inputs are changed only on the falling edge between requests, so each property sees stable inputs across the edge it reasons about.

// File: rtl/smram_guard_pkg.sv
package smram_guard_pkg;
  localparam int REG_W = 8;

  localparam int BIT_HI_EN = 7;
  localparam int BIT_ERR = 6;
  localparam int BIT_SZ_HI = 2;
  localparam int BIT_SZ_LO = 1;

  localparam logic [REG_W-1:0] REG_RESET = 8'h38;
  localparam logic [2:0] FIXED_ONES = 3'b111;

  localparam logic [1:0] SEG_CODE_1MB = 2'b00;
  localparam logic [1:0] SEG_CODE_2MB = 2'b01;

  typedef struct packed {
    logic hiWinOn;
    logic segOn;
    logic segDouble;
  } winCtl_t;
endpackage

// File: rtl/smram_guard_ctrl.sv
module smram_guard_ctrl
  import smram_guard_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [REG_W-1:0] cfgWrData,
  input  logic             lockIn,
  input  logic             smramEnIn,
  input  logic             violation,
  output winCtl_t          winCtl,
  output logic [REG_W-1:0] cfgRdData
);
  localparam logic [1:0] RST_CODE = REG_RESET[BIT_SZ_HI:BIT_SZ_LO];

  logic       hiEn;
  logic       errSticky;
  logic [1:0] segCode;
  logic       wrAllowed;
  logic       clrReq;

  assign wrAllowed = cfgWrEn & ~lockIn;
  assign clrReq = cfgWrEn & cfgWrData[BIT_ERR];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiEn      <= REG_RESET[BIT_HI_EN];
      segCode   <= RST_CODE;
      errSticky <= REG_RESET[BIT_ERR];
    end else begin
      if (wrAllowed) begin
        hiEn    <= cfgWrData[BIT_HI_EN];
        segCode <= cfgWrData[BIT_SZ_HI:BIT_SZ_LO];
      end
      if (violation) begin
        errSticky <= 1'b1;
      end else if (clrReq) begin
        errSticky <= 1'b0;
      end
    end
  end

  always_comb begin
    winCtl.hiWinOn   = smramEnIn & hiEn;
    winCtl.segOn     = (segCode == SEG_CODE_1MB) | (segCode == SEG_CODE_2MB);
    winCtl.segDouble = (segCode == SEG_CODE_2MB);
  end

  always_comb begin
    cfgRdData = '0;
    cfgRdData[BIT_HI_EN] = hiEn;
    cfgRdData[BIT_ERR] = errSticky;
    cfgRdData[5:3] = FIXED_ONES;
    cfgRdData[BIT_SZ_HI:BIT_SZ_LO] = segCode;
  end
endmodule

// File: rtl/smram_guard_dp.sv
module smram_guard_dp
  import smram_guard_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] HI_BASE = 32'hFEDA_0000,
  parameter logic [ADDR_W-1:0] HI_LAST = 32'hFEDB_FFFF,
  parameter logic [ADDR_W-1:0] LEGACY_BASE = 32'h000A_0000,
  parameter logic [ADDR_W-1:0] SEG_UNIT = 32'h0010_0000
) (
  input  winCtl_t           winCtl,
  input  logic              reqValid,
  input  logic              reqSmm,
  input  logic              openOvr,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:0] topMem,
  input  logic [ADDR_W-1:0] gttSize,
  input  logic [ADDR_W-1:0] stolenSize,
  output logic              routeIo,
  output logic [ADDR_W-1:0] dramAddr,
  output logic              violation
);
  localparam logic [ADDR_W-1:0] HI_SHIFT = HI_BASE - LEGACY_BASE;

  logic [ADDR_W-1:0] segEnd;
  logic [ADDR_W-1:0] segLen;
  logic [ADDR_W-1:0] segBase;
  logic              inHigh;
  logic              hiHit;
  logic              segHit;
  logic              privileged;

  always_comb begin
    segEnd  = topMem - gttSize - stolenSize;
    segLen  = winCtl.segDouble ? (SEG_UNIT << 1) : SEG_UNIT;
    segBase = segEnd - segLen;
  end

  assign inHigh = (reqAddr >= HI_BASE) && (reqAddr <= HI_LAST);
  assign hiHit = winCtl.hiWinOn & inHigh;
  assign segHit = winCtl.segOn && (reqAddr >= segBase) && (reqAddr < segEnd);
  assign privileged = reqSmm | openOvr;

  assign violation = reqValid & ~privileged & (hiHit | segHit);
  assign routeIo = violation;
  assign dramAddr = hiHit ? (reqAddr - HI_SHIFT) : reqAddr;
endmodule

// File: rtl/smram_guard.sv
module smram_guard
  import smram_guard_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [7:0]        cfgWrData,
  output logic [7:0]        cfgRdData,
  input  logic              lockIn,
  input  logic              smramEnIn,
  input  logic              openOvr,
  input  logic              reqValid,
  input  logic              reqSmm,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:0] topMem,
  input  logic [ADDR_W-1:0] gttSize,
  input  logic [ADDR_W-1:0] stolenSize,
  output logic              routeIo,
  output logic [ADDR_W-1:0] dramAddr
);
  winCtl_t winCtl;
  logic    violation;

  smram_guard_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .lockIn(lockIn), .smramEnIn(smramEnIn), .violation(violation),
    .winCtl(winCtl), .cfgRdData(cfgRdData)
  );

  smram_guard_dp #(.ADDR_W(ADDR_W)) u_dp (
    .winCtl(winCtl), .reqValid(reqValid), .reqSmm(reqSmm), .openOvr(openOvr),
    .reqAddr(reqAddr), .topMem(topMem), .gttSize(gttSize),
    .stolenSize(stolenSize), .routeIo(routeIo), .dramAddr(dramAddr),
    .violation(violation)
  );
endmodule

// File: rtl/smram_guard_chk.sv
module smram_guard_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cfgWrEn,
  input logic [7:0] cfgWrData,
  input logic [7:0] cfgRdData,
  input logic       lockIn,
  input logic       openOvr,
  input logic       reqValid,
  input logic       reqSmm,
  input logic       routeIo
);
  // R2: constant fields at the read port
  p_fixed_bits_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdData[5:3] == 3'b111) && (cfgRdData[0] == 1'b0));

  // R3: locked fields hold across a locked edge
  p_lock_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    lockIn |=> (cfgRdData[7] == $past(cfgRdData[7])) &&
               (cfgRdData[2:1] == $past(cfgRdData[2:1])));

  // R7: forwarded non-management request latches the error
  p_err_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && routeIo) |=> cfgRdData[6]);

  // R7: no forwarding without a request
  p_idle_no_io_r7: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> !routeIo);

  // R9: privileged requests stay on DRAM
  p_priv_dram_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (reqSmm || openOvr)) |-> !routeIo);

  // R10: write-one clears when nothing sets
  p_err_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgWrData[6] && !(reqValid && routeIo)) |=> !cfgRdData[6]);

  // R10: sticky without a clearing write
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdData[6] && !(cfgWrEn && cfgWrData[6])) |=> cfgRdData[6]);
endmodule

bind smram_guard smram_guard_chk u_chk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
  .cfgRdData(cfgRdData), .lockIn(lockIn), .openOvr(openOvr),
  .reqValid(reqValid), .reqSmm(reqSmm), .routeIo(routeIo)
);

// File: tb/sim_smram_guard.sv
`timescale 1ns/1ps
module sim_smram_guard;
  localparam logic [31:0] MB = 32'h0010_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgWrData = '0;
  logic [7:0]  cfgRdData;
  logic        lockIn = 1'b0;
  logic        smramEnIn = 1'b0;
  logic        openOvr = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqSmm = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [31:0] topMem = 32'h8000_0000;
  logic [31:0] gttSize = 32'h0020_0000;
  logic [31:0] stolenSize = 32'h0400_0000;
  logic        routeIo;
  logic [31:0] dramAddr;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  // reference state
  bit         mHi = 0;
  bit         mErr = 0;
  logic [1:0] mSz = 2'b00;

  always #4 clk = ~clk;

  smram_guard u0 (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .lockIn(lockIn), .smramEnIn(smramEnIn),
    .openOvr(openOvr), .reqValid(reqValid), .reqSmm(reqSmm),
    .reqAddr(reqAddr), .topMem(topMem), .gttSize(gttSize),
    .stolenSize(stolenSize), .routeIo(routeIo), .dramAddr(dramAddr)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // compare this cycle's outputs against the model, then advance one clock
  task automatic step(input string tag);
    logic [31:0] segEnd, segBase, expAddr;
    bit inHigh, hiOn, segOn, inSeg, blocked;
    #1;
    hiOn = smramEnIn && mHi;
    segOn = (mSz == 2'b00) || (mSz == 2'b01);
    segEnd = topMem - gttSize - stolenSize;
    segBase = segEnd - ((mSz == 2'b01) ? 2 * MB : MB);
    inHigh = (reqAddr >= 32'hFEDA_0000) && (reqAddr <= 32'hFEDB_FFFF);
    inSeg = (reqAddr >= segBase) && (reqAddr < segEnd);
    blocked = reqValid && !reqSmm && !openOvr && ((inHigh && hiOn) || (inSeg && segOn));
    expAddr = (inHigh && hiOn) ? (reqAddr - 32'hFEDA_0000 + 32'h000A_0000) : reqAddr;
    check(tag, "cfgRdData", {24'h0, cfgRdData}, {24'h0, mHi, mErr, 3'b111, mSz, 1'b0});
    check(tag, "routeIo", {31'h0, routeIo}, {31'h0, blocked});
    if (reqValid && !blocked) check(tag, "dramAddr", dramAddr, expAddr);
    @(posedge clk);
    if (blocked) mErr = 1;
    else if (cfgWrEn && cfgWrData[6]) mErr = 0;
    if (cfgWrEn && !lockIn) begin
      mHi = cfgWrData[7];
      mSz = cfgWrData[2:1];
    end
    @(negedge clk);
    cfgWrEn = 0;
    reqValid = 0;
  endtask

  task automatic wr(input logic [7:0] d, input string tag);
    cfgWrEn = 1;
    cfgWrData = d;
    step(tag);
  endtask

  task automatic rq(input logic [31:0] a, input bit smm, input string tag);
    reqValid = 1;
    reqAddr = a;
    reqSmm = smm;
    step(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    check("R1", "reset value", {24'h0, cfgRdData}, 32'h38);
    step("R1");
    wr(8'hFF, "R2");
    step("R3");
    // code 11: segment off, 1MB slot just under the end reaches DRAM
    rq(32'h7BDF_0000, 0, "R8");
    wr(8'h04, "R8");
    rq(32'h7BC0_0000, 0, "R8");
    // high window enable, segment 1MB
    wr(8'h80, "R3");
    smramEnIn = 1;
    rq(32'hFEDA_0000, 1, "R4");
    rq(32'hFEDB_FFFF, 1, "R4");
    openOvr = 1;
    rq(32'hFEDA_1234, 0, "R9");
    rq(32'h7BD8_0000, 0, "R9");
    openOvr = 0;
    step("R9");
    rq(32'hFEDA_0010, 0, "R7");
    step("R7");
    wr(8'h80, "R10");
    step("R10");
    wr(8'hC0, "R10");
    step("R10");
    // idle with address inside the window
    reqAddr = 32'hFEDA_0000;
    reqSmm = 0;
    step("R7");
    step("R7");
    // segment boundaries, 1MB: end 0x7BE00000
    rq(32'h7BCF_FFFF, 0, "R6");
    step("R6");
    rq(32'h7BD0_0000, 0, "R6");
    wr(8'hC0, "R10");
    rq(32'h7BDF_FFFF, 0, "R6");
    wr(8'hC0, "R10");
    rq(32'h7BE0_0000, 0, "R6");
    step("R6");
    // lock freezes fields
    lockIn = 1;
    wr(8'h02, "R3");
    step("R3");
    lockIn = 0;
    // 2MB segment
    wr(8'h82, "R6");
    rq(32'h7BC0_0000, 0, "R6");
    wr(8'hC2, "R10");
    rq(32'h7BBF_FFFF, 0, "R6");
    // simultaneous set and clear
    cfgWrEn = 1;
    cfgWrData = 8'hC2;
    rq(32'h7BC0_0000, 0, "R11");
    step("R11");
    wr(8'hC2, "R10");
    // global enable off: window passes through
    smramEnIn = 0;
    rq(32'hFEDA_0000, 0, "R5");
    rq(32'hFEDB_0004, 0, "R5");
    step("R5");
    smramEnIn = 1;
    wr(8'h42, "R5");
    rq(32'hFEDA_0020, 0, "R5");
    step("R5");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule